// File: doc/BRIEF.md
# Address-Match Breakpoint Trigger Bank

This unit gives a processor core a small set of hardware breakpoints. Software picks one trigger at a time through an index register, then programs that trigger through a configuration word and a target-address register. All triggers remain armed together, whichever one the index currently points at. A separate gate register holds the machine-mode enable. While that enable is clear, no trigger can fire.

The core presents one memory request per cycle. The request is an instruction fetch, a load or a store. The unit compares the request against every armed trigger in the same cycle. On a hit it raises a breakpoint request with exception code 3 and reports the faulting instruction address. It also reports which triggers matched. For a store it drives a block signal so that the write never reaches memory. Configuration registers are legalized on write: an unsupported trigger type or index reads back as something other than what was written, and software uses that difference to discover what is implemented.

Top module: `brk_trig_unit`

## Requirements
- R1: After a synchronous reset the index reads 0, every trigger's configuration and target read 0, the gate reads 0, and no request produces a hit.
- R2: On a configuration write (csr_addr 1), the type field in bits [XLEN-1:XLEN-4] is accepted only if its value is 2. In that case the stored word keeps the type plus bits 0 (load), 1 (store), 2 (execute) and 6 (machine mode), and every other bit reads 0. Any other type value stores an all-zero word.
- R3: The index register (csr_addr 0) reads back the value written when that value is below NTRIG, and NTRIG-1 otherwise. Configuration (csr_addr 1) and target (csr_addr 2) accesses reach the trigger the index selects.
- R4: The gate register (csr_addr 3) keeps only bit 3 and reads 0 in all other bits. While bit 3 is clear, no trigger fires.
- R5: Request kinds are encoded as 0 fetch, 1 load, 2 store and 3 none. A fetch is compared using req_pc and needs the execute bit. A load or store is compared using req_addr and needs the load bit or the store bit respectively. Kind 3, or req_valid low, never hits.
- R6: A trigger whose machine-mode bit (bit 6) is clear never fires.
- R7: The compare is exact equality over all XLEN bits of the address.
- R8: hit_vec bit i is set exactly when trigger i matches. Triggers match independently of each other. brk_hit is the OR of hit_vec.
- R9: When brk_hit is high, brk_cause is 3 and brk_epc equals req_pc. Otherwise both are 0.
- R10: store_block is high exactly when brk_hit is high for a store request.
- R11: Hit outputs follow the request inputs within the same cycle. A register write affects hits and reads only from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 index, 1 configuration, 2 target, 3 gate |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data for csr_addr |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 none |
| req_addr | input | XLEN | Load/store effective address |
| req_pc | input | XLEN | Address of the requesting instruction |
| brk_hit | output | 1 | Breakpoint exception request |
| hit_vec | output | NTRIG | Per-trigger match flags |
| brk_cause | output | XLEN | Exception code (3 on hit) |
| brk_epc | output | XLEN | Faulting instruction address on hit |
| store_block | output | 1 | Suppress the store's memory write |

## Verification
The hardest case to reach is two triggers armed at once while the index points at only one of them. The stimulus programs trigger 1 after an over-range index write, which also exercises the clamp. It then moves the index back to trigger 0, reprograms it, and aims both triggers at the same address so that a single load sets both hit_vec bits. A second situation depends on timing: a request is presented in the same cycle as the target-address write that would make it match. The reference model must then expect no hit until the following cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    REG_INDEX  = 2'd0,
    REG_CONFIG = 2'd1,
    REG_TARGET = 2'd2,
    REG_GATE   = 2'd3
  } reg_sel_e;

  localparam int CB_LOAD  = 0;
  localparam int CB_STORE = 1;
  localparam int CB_EXEC  = 2;
  localparam int CB_MMODE = 6;
  localparam int GATE_BIT = 3;
  localparam int TYPE_W   = 4;
  localparam logic [TYPE_W-1:0] TYPE_ADDR = 4'd2;
  localparam int EXC_BREAK = 3;

endpackage

// File: rtl/brk_csr_bank.sv
module brk_csr_bank
  import brk_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [1:0]       csr_addr,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic [NTRIG-1:0] armed,
  output logic [NTRIG-1:0] en_load,
  output logic [NTRIG-1:0] en_store,
  output logic [NTRIG-1:0] en_exec,
  output logic [NTRIG-1:0][XLEN-1:0] target,
  output logic             gate_on
);

  localparam int SELW = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam logic [SELW-1:0] SEL_MAX = SELW'(NTRIG - 1);

  logic [SELW-1:0] sel_q;
  logic [NTRIG-1:0][XLEN-1:0] cfg_q;
  logic [NTRIG-1:0][XLEN-1:0] tgt_q;
  logic gate_q;
  reg_sel_e rsel;

  assign rsel = reg_sel_e'(csr_addr);

  function automatic logic [XLEN-1:0] legalize(input logic [XLEN-1:0] w);
    logic [XLEN-1:0] r;
    r = '0;
    if (w[XLEN-1 -: TYPE_W] == TYPE_ADDR) begin
      r[XLEN-1 -: TYPE_W] = TYPE_ADDR;
      r[CB_LOAD]  = w[CB_LOAD];
      r[CB_STORE] = w[CB_STORE];
      r[CB_EXEC]  = w[CB_EXEC];
      r[CB_MMODE] = w[CB_MMODE];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      gate_q <= 1'b0;
    end else if (csr_we) begin
      if (rsel == REG_INDEX) begin
        if (csr_wdata >= XLEN'(NTRIG)) sel_q <= SEL_MAX;
        else sel_q <= csr_wdata[SELW-1:0];
      end
      if (rsel == REG_GATE) gate_q <= csr_wdata[GATE_BIT];
    end
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
        tgt_q[i] <= '0;
      end else if (csr_we && (sel_q == SELW'(i))) begin
        if (rsel == REG_CONFIG) cfg_q[i] <= legalize(csr_wdata);
        if (rsel == REG_TARGET) tgt_q[i] <= csr_wdata;
      end
    end
    assign armed[i]    = (cfg_q[i][XLEN-1 -: TYPE_W] == TYPE_ADDR) && cfg_q[i][CB_MMODE];
    assign en_load[i]  = cfg_q[i][CB_LOAD];
    assign en_store[i] = cfg_q[i][CB_STORE];
    assign en_exec[i]  = cfg_q[i][CB_EXEC];
    assign target[i]   = tgt_q[i];
  end

  assign gate_on = gate_q;

  always_comb begin
    csr_rdata = '0;
    unique case (rsel)
      REG_INDEX:  csr_rdata = XLEN'(sel_q);
      REG_CONFIG: csr_rdata = cfg_q[sel_q];
      REG_TARGET: csr_rdata = tgt_q[sel_q];
      REG_GATE:   csr_rdata[GATE_BIT] = gate_q;
      default:    csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
  import brk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            armed,
  input  logic            en_load,
  input  logic            en_store,
  input  logic            en_exec,
  input  logic [XLEN-1:0] target,
  input  logic            gate_on,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [XLEN-1:0] req_addr,
  input  logic [XLEN-1:0] req_pc,
  output logic            hit
);

  acc_kind_e kind;
  logic kind_ok;
  logic [XLEN-1:0] probe;

  assign kind = acc_kind_e'(req_kind);

  always_comb begin
    kind_ok = 1'b0;
    probe   = req_addr;
    unique case (kind)
      ACC_FETCH: begin kind_ok = en_exec; probe = req_pc; end
      ACC_LOAD:  kind_ok = en_load;
      ACC_STORE: kind_ok = en_store;
      default:   kind_ok = 1'b0;
    endcase
  end

  assign hit = req_valid && gate_on && armed && kind_ok && (probe == target);

endmodule

// File: rtl/brk_hit_merge.sv
module brk_hit_merge
  import brk_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 2
) (
  input  logic [NTRIG-1:0] hits,
  input  logic [1:0]       req_kind,
  input  logic [XLEN-1:0]  req_pc,
  output logic             any_hit,
  output logic [XLEN-1:0]  cause,
  output logic [XLEN-1:0]  epc,
  output logic             blk
);

  assign any_hit = |hits;
  assign cause   = any_hit ? XLEN'(EXC_BREAK) : '0;
  assign epc     = any_hit ? req_pc : '0;
  assign blk     = any_hit && (acc_kind_e'(req_kind) == ACC_STORE);

endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
  import brk_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [1:0]       csr_addr,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [XLEN-1:0]  req_addr,
  input  logic [XLEN-1:0]  req_pc,
  output logic             brk_hit,
  output logic [NTRIG-1:0] hit_vec,
  output logic [XLEN-1:0]  brk_cause,
  output logic [XLEN-1:0]  brk_epc,
  output logic             store_block
);

  logic [NTRIG-1:0] armed, en_load, en_store, en_exec;
  logic [NTRIG-1:0][XLEN-1:0] target;
  logic gate_on;

  brk_csr_bank #(.XLEN(XLEN), .NTRIG(NTRIG)) u_bank (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .armed(armed),
    .en_load(en_load), .en_store(en_store), .en_exec(en_exec),
    .target(target), .gate_on(gate_on)
  );

  for (genvar i = 0; i < NTRIG; i++) begin : g_cmp
    brk_addr_cmp #(.XLEN(XLEN)) u_cmp (
      .armed(armed[i]), .en_load(en_load[i]), .en_store(en_store[i]),
      .en_exec(en_exec[i]), .target(target[i]), .gate_on(gate_on),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_pc(req_pc), .hit(hit_vec[i])
    );
  end

  brk_hit_merge #(.XLEN(XLEN), .NTRIG(NTRIG)) u_merge (
    .hits(hit_vec), .req_kind(req_kind), .req_pc(req_pc),
    .any_hit(brk_hit), .cause(brk_cause), .epc(brk_epc), .blk(store_block)
  );

endmodule

// File: rtl/brk_trig_chk.sv
module brk_trig_chk #(
  parameter int XLEN  = 64,
  parameter int NTRIG = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_we,
  input logic [1:0]       csr_addr,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [XLEN-1:0]  req_pc,
  input logic             brk_hit,
  input logic [NTRIG-1:0] hit_vec,
  input logic [XLEN-1:0]  brk_cause,
  input logic [XLEN-1:0]  brk_epc,
  input logic             store_block
);

  logic gate_shadow;

  always_ff @(posedge clk) begin
    if (rst) gate_shadow <= 1'b0;
    else if (csr_we && csr_addr == 2'd3)
      gate_shadow <= |(csr_wdata & XLEN'(8));
  end

  assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    !gate_shadow |-> !brk_hit);

  assert_gate_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 2'd3) |-> (csr_rdata == (gate_shadow ? XLEN'(8) : '0)));

  assert_idle_no_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_kind == 2'd3) |-> !brk_hit);

  assert_vec_or_R8: assert property (@(posedge clk) disable iff (rst)
    brk_hit == (hit_vec != '0));

  assert_cause_epc_R9: assert property (@(posedge clk) disable iff (rst)
    brk_hit |-> (brk_cause == XLEN'(3) && brk_epc == req_pc));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !brk_hit |-> (brk_cause == '0 && brk_epc == '0));

  assert_block_store_R10: assert property (@(posedge clk) disable iff (rst)
    store_block == (brk_hit && req_kind == 2'd2));

  assert_index_range_R3: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 2'd0) |-> (csr_rdata < XLEN'(NTRIG)));

  assert_type_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 2'd1) |-> (csr_rdata[XLEN-1 -: 4] == 4'd0 || csr_rdata[XLEN-1 -: 4] == 4'd2));

endmodule

bind brk_trig_unit brk_trig_chk #(.XLEN(XLEN), .NTRIG(NTRIG)) u_chk (.*);

// File: tb/sim_brk_trig_unit.sv
`timescale 1ns/1ps
module sim_brk_trig_unit;

  localparam int XLEN  = 64;
  localparam int NTRIG = 2;
  localparam logic [63:0] T2 = 64'h2000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = 2'd0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [63:0] req_addr = '0;
  logic [63:0] req_pc = '0;
  logic brk_hit;
  logic [NTRIG-1:0] hit_vec;
  logic [63:0] brk_cause, brk_epc;
  logic store_block;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_cfg [NTRIG];
  logic [63:0] m_tgt [NTRIG];
  int m_sel;
  bit m_gate;

  always #4 clk = ~clk;

  brk_trig_unit #(.XLEN(XLEN), .NTRIG(NTRIG)) u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_pc(req_pc),
    .brk_hit(brk_hit), .hit_vec(hit_vec), .brk_cause(brk_cause),
    .brk_epc(brk_epc), .store_block(store_block)
  );

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return 64'(m_sel);
      2'd1: return m_cfg[m_sel];
      2'd2: return m_tgt[m_sel];
      default: return m_gate ? 64'd8 : 64'd0;
    endcase
  endfunction

  function automatic logic [NTRIG-1:0] model_hits(input bit v, input logic [1:0] k,
                                                   input logic [63:0] ad, input logic [63:0] pc);
    logic [NTRIG-1:0] h = '0;
    for (int i = 0; i < NTRIG; i++) begin
      bit on = v && m_gate && (m_cfg[i][63:60] == 4'd2) && m_cfg[i][6];
      if (k == 2'd0) h[i] = on && m_cfg[i][2] && (pc == m_tgt[i]);
      else if (k == 2'd1) h[i] = on && m_cfg[i][0] && (ad == m_tgt[i]);
      else if (k == 2'd2) h[i] = on && m_cfg[i][1] && (ad == m_tgt[i]);
    end
    return h;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [63:0] w);
    case (a)
      2'd0: m_sel = (w >= 64'(NTRIG)) ? NTRIG - 1 : int'(w);
      2'd1: m_cfg[m_sel] = (w[63:60] == 4'd2) ? (T2 | (w & 64'h47)) : 64'd0;
      2'd2: m_tgt[m_sel] = w;
      default: m_gate = w[3];
    endcase
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [63:0] wd,
                      input bit v, input logic [1:0] k, input logic [63:0] ad,
                      input logic [63:0] pc, input string tag);
    logic [NTRIG-1:0] eh;
    csr_we = we; csr_addr = a; csr_wdata = wd;
    req_valid = v; req_kind = k; req_addr = ad; req_pc = pc;
    #2;
    eh = model_hits(v, k, ad, pc);
    cmp(tag, "csr_rdata", csr_rdata, model_read(a));
    cmp(tag, "hit_vec", 64'(hit_vec), 64'(eh));
    cmp(tag, "brk_hit", 64'(brk_hit), 64'(|eh));
    cmp(tag, "brk_cause", brk_cause, (|eh) ? 64'd3 : 64'd0);
    cmp(tag, "brk_epc", brk_epc, (|eh) ? pc : 64'd0);
    cmp(tag, "store_block", 64'(store_block), 64'((|eh) && k == 2'd2));
    @(posedge clk);
    if (we) model_write(a, wd);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] w, input string tag);
    step(1, a, w, 0, 2'd3, 0, 0, tag);
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    step(0, a, 0, 0, 2'd3, 0, 0, tag);
  endtask
  task automatic rq(input logic [1:0] k, input logic [63:0] ad, input logic [63:0] pc, input string tag);
    step(0, 2'd0, 0, 1, k, ad, pc, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NTRIG; i++) begin m_cfg[i] = '0; m_tgt[i] = '0; end
    m_sel = 0; m_gate = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");
    rq(2'd0, 64'h0, 64'h0, "R1");
    // R4 gate keeps only bit 3
    wr(2'd3, 64'hFFFF, "R4"); rd(2'd3, "R4");
    // R2 legal execute trigger
    wr(2'd1, T2 | 64'h44, "R2"); rd(2'd1, "R2");
    wr(2'd2, 64'h100, "R2");
    rq(2'd0, 64'h0, 64'h100, "R5 fetch hit");
    rq(2'd1, 64'h100, 64'h80, "R5 load on exec trigger");
    rq(2'd0, 64'h100, 64'h104, "R7 near miss");
    rq(2'd0, 64'h0, 64'h8000_0000_0000_0100, "R7 high bit");
    // R4 gate off blocks
    wr(2'd3, 64'h0, "R4"); rq(2'd0, 64'h0, 64'h100, "R4 gated");
    wr(2'd3, 64'h8, "R4");
    // R11 write and request in the same cycle
    step(1, 2'd2, 64'h200, 1, 2'd0, 64'h0, 64'h200, "R11 same cycle");
    rq(2'd0, 64'h0, 64'h200, "R11 next cycle");
    // R5 load trigger, store not matched
    wr(2'd1, T2 | 64'h41, "R5");
    rq(2'd1, 64'h200, 64'h40, "R5 load hit");
    rq(2'd2, 64'h200, 64'h44, "R5 store on load trigger");
    // R10 store trigger blocks
    wr(2'd1, T2 | 64'h42, "R10");
    rq(2'd2, 64'h200, 64'h48, "R10 store hit");
    rq(2'd3, 64'h200, 64'h48, "R5 kind none");
    step(0, 2'd0, 0, 0, 2'd2, 64'h200, 64'h48, "R5 invalid");
    // R6 machine-mode bit clear
    wr(2'd1, T2 | 64'h02, "R6"); rq(2'd2, 64'h200, 64'h4c, "R6 no M");
    // R2 illegal types
    wr(2'd1, 64'h3000_0000_0000_0047, "R2"); rd(2'd1, "R2 bad type");
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R2"); rd(2'd1, "R2 all ones");
    wr(2'd1, T2 | 64'h0FFF_FFFF_FFFF_FFFF, "R2"); rd(2'd1, "R2 masked");
    // R3 index clamp and second trigger
    wr(2'd0, 64'd5, "R3"); rd(2'd0, "R3 clamp");
    wr(2'd1, T2 | 64'h41, "R3"); wr(2'd2, 64'h300, "R3");
    rq(2'd1, 64'h300, 64'h10, "R8 trigger1");
    wr(2'd0, 64'd0, "R3"); rd(2'd2, "R3 back to 0"); rd(2'd1, "R3 cfg0");
    wr(2'd1, T2 | 64'h43, "R8");
    rq(2'd2, 64'h200, 64'h14, "R8 trigger0 store");
    rq(2'd1, 64'h300, 64'h18, "R8 trigger1 load");
    wr(2'd2, 64'h300, "R8");
    rq(2'd1, 64'h300, 64'h1c, "R8 both");
    rq(2'd2, 64'h300, 64'h20, "R10 store one");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule